// File: doc/BRIEF.md
# Processor Interrupt Pin Conditioner

This block sits between a processor's external control pins and its pending-interrupt logic. Each clock it samples a vector of pin slots through a synchroniser. It keeps the last accepted level of every known pin and reacts only when a pin's synchronised level differs from that stored level. Each known pin follows its own sensitivity rule:

- external interrupt, system-management interrupt and soft reset are level sensitive and each drive a pending bit;
- machine-check is caught on a falling edge and latched;
- checkstop drives a halt output;
- hard reset is only recorded.

A registered summary request is high whenever any pending bit is set. The core clears latched bits with an acknowledge vector. Acknowledging a level-sensitive source has no effect while that pin is still high. Slots above the known pins are treated as unknown and ignored.

Pin slot encoding of `pin_i`: bit 0 external interrupt, bit 1 system-management interrupt, bit 2 machine-check, bit 3 checkstop, bit 4 hard reset, bit 5 soft reset, bits 6 and up unknown. Pending encoding of `pend_o` and `ack_i`: bit 0 external, bit 1 system-management, bit 2 machine-check, bit 3 soft reset.

Top module: `cpu_pin_cond`

## Requirements
- R1: A level change on `pin_i` reaches `pin_state_o`, `pend_o`, `irq_o` and `halt_o` at the third rising edge after it is applied, and not before (SYNC_STAGES = 2 synchroniser flops plus one state register).
- R2: A known pin's bit in `pin_state_o` updates only when its synchronised level differs from the stored level. A repeated level changes no output.
- R3: Pin slots 6 and above are unknown. Their `pin_state_o` bits stay 0 and they change no other output.
- R4: Pending bit 0 (pin bit 0) and pending bit 1 (pin bit 1) are set when their pin is accepted high and cleared when it is accepted low.
- R5: Pending bit 2 is set only when pin bit 2 is accepted falling (stored 1, new 0). A rising edge neither sets nor clears it.
- R6: `halt_o` is 1 while the accepted checkstop level (pin bit 3) is 1, and 0 when it is 0.
- R7: Pending bit 3 follows the accepted soft-reset level (pin bit 5), set when high and cleared when low.
- R8: An accepted change of pin bit 4 (hard reset) updates only `pin_state_o[4]`. `pend_o`, `irq_o` and `halt_o` are unaffected.
- R9: `irq_o` is 1 exactly when any `pend_o` bit is 1. Clearing one bit while another remains keeps it high.
- R10: An `ack_i` bit clears its pending bit at the next rising edge. It wins over a machine-check set at that same edge. It has no effect on a level-sensitive bit whose pin is still high.
- R11: A synchronous `rst` clears `pin_state_o`, `pend_o`, `irq_o`, `halt_o` and the synchroniser at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_i | input | PIN_SLOTS | Raw pin levels, slot encoding above |
| ack_i | input | 4 | Per-bit clear of pending sources |
| pend_o | output | 4 | Pending interrupt bits |
| irq_o | output | 1 | Summary interrupt request |
| halt_o | output | 1 | Core halt from checkstop |
| pin_state_o | output | PIN_SLOTS | Last accepted level of each slot |

## Verification
A pin change driven at a falling clock edge is due on all outputs three rising edges later. An acknowledge is due one rising edge after it is applied. For every pin stimulus, the driver queues two expectations: the unchanged outputs at the second edge and the new outputs at the third. The monitor compares each one at the falling edge after its due edge. For the acknowledge race, the acknowledge is timed so that it is high at exactly the edge where the falling machine-check edge is accepted.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  // pin slot positions
  localparam int PIN_EXT    = 0;
  localparam int PIN_SMI    = 1;
  localparam int PIN_MCK    = 2;
  localparam int PIN_CSTOP  = 3;
  localparam int PIN_HRST   = 4;
  localparam int PIN_SRST   = 5;
  localparam int KNOWN_PINS = 6;

  // pending bit positions
  localparam int PB_EXT  = 0;
  localparam int PB_SMI  = 1;
  localparam int PB_MCK  = 2;
  localparam int PB_SRST = 3;
  localparam int PEND_W  = 4;

  typedef logic [PEND_W-1:0] pend_t;

  // order of the level-sensitive group: ext, smi, soft reset
  localparam int LVL_N = 3;

  function automatic pend_t place_level(input logic [LVL_N-1:0] v);
    pend_t r;
    r          = '0;
    r[PB_EXT]  = v[0];
    r[PB_SMI]  = v[1];
    r[PB_SRST] = v[2];
    return r;
  endfunction

  // clear first, then set; acknowledge last, masked by held levels
  function automatic pend_t pend_update(input pend_t cur, input pend_t set,
                                        input pend_t clr, input pend_t ack,
                                        input pend_t hold);
    return ((cur & ~clr) | set) & ~(ack & ~hold);
  endfunction
endpackage

// File: rtl/cpc_sync.sv
module cpc_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] r;
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) r <= '0;
        else     r <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) r <= '0;
        else     r <= g_stage[s-1].r;
      end
    end
  end

  assign q_o = g_stage[STAGES-1].r;
endmodule

// File: rtl/cpc_change_det.sv
module cpc_change_det
  import cpc_pkg::*;
#(
  parameter int SLOTS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [SLOTS-1:0]      lvl_i,
  output logic [SLOTS-1:0]      state_o,
  output logic [KNOWN_PINS-1:0] evt_o,
  output logic [SLOTS-1:0]      ign_o
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i < KNOWN_PINS) begin : g_known
      logic st;
      always_ff @(posedge clk) begin
        if (rst)                 st <= 1'b0;
        else if (lvl_i[i] != st) st <= lvl_i[i];
      end
      assign state_o[i] = st;
      assign evt_o[i]   = lvl_i[i] ^ st;
      assign ign_o[i]   = 1'b0;
    end else begin : g_unknown
      // stored level of an unknown slot is held at zero
      assign state_o[i] = 1'b0;
      assign ign_o[i]   = lvl_i[i];
    end
  end
endmodule

// File: rtl/cpc_pend_ctrl.sv
module cpc_pend_ctrl
  import cpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_N-1:0] lvl_evt_i,
  input  logic [LVL_N-1:0] lvl_val_i,
  input  logic             mck_fall_i,
  input  logic             stop_evt_i,
  input  logic             stop_val_i,
  input  pend_t            ack_i,
  output pend_t            pend_o,
  output logic             irq_o,
  output logic             halt_o
);
  pend_t pend_q, pend_d, set_v, clr_v, hold_v;
  logic  irq_q, halt_q;

  always_comb begin
    set_v         = place_level(lvl_evt_i & lvl_val_i);
    set_v[PB_MCK] = mck_fall_i;
    clr_v         = place_level(lvl_evt_i & ~lvl_val_i);
    hold_v        = place_level(lvl_val_i);
    pend_d        = pend_update(pend_q, set_v, clr_v, ack_i, hold_v);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= |pend_d;
      if (stop_evt_i) halt_q <= stop_val_i;
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = irq_q;
  assign halt_o = halt_q;
endmodule

// File: rtl/cpu_pin_cond.sv
module cpu_pin_cond
  import cpc_pkg::*;
#(
  parameter int PIN_SLOTS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PIN_SLOTS-1:0] pin_i,
  input  logic [3:0]           ack_i,
  output logic [3:0]           pend_o,
  output logic                 irq_o,
  output logic                 halt_o,
  output logic [PIN_SLOTS-1:0] pin_state_o
);
  logic [PIN_SLOTS-1:0]  pin_sync;
  logic [KNOWN_PINS-1:0] pin_evt;
  logic [KNOWN_PINS-1:0] pin_lvl;
  logic [PIN_SLOTS-1:0]  ign_evt;
  logic [LVL_N-1:0]      lvl_evt, lvl_val;
  logic                  mck_fall;

  cpc_sync #(.W(PIN_SLOTS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(pin_i), .q_o(pin_sync)
  );

  cpc_change_det #(.SLOTS(PIN_SLOTS)) u_det (
    .clk(clk), .rst(rst), .lvl_i(pin_sync),
    .state_o(pin_state_o), .evt_o(pin_evt), .ign_o(ign_evt)
  );

  assign pin_lvl  = pin_sync[KNOWN_PINS-1:0];
  assign lvl_evt  = {pin_evt[PIN_SRST], pin_evt[PIN_SMI], pin_evt[PIN_EXT]};
  assign lvl_val  = {pin_lvl[PIN_SRST], pin_lvl[PIN_SMI], pin_lvl[PIN_EXT]};
  assign mck_fall = pin_evt[PIN_MCK] & ~pin_lvl[PIN_MCK];

  cpc_pend_ctrl u_pend (
    .clk(clk), .rst(rst),
    .lvl_evt_i(lvl_evt), .lvl_val_i(lvl_val),
    .mck_fall_i(mck_fall),
    .stop_evt_i(pin_evt[PIN_CSTOP]), .stop_val_i(pin_lvl[PIN_CSTOP]),
    .ack_i(ack_i), .pend_o(pend_o), .irq_o(irq_o), .halt_o(halt_o)
  );
endmodule

// File: rtl/cpu_pin_cond_chk.sv
module cpu_pin_cond_chk
  import cpc_pkg::*;
#(
  parameter int PIN_SLOTS = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic [3:0]            ack_i,
  input logic [3:0]            pend_o,
  input logic                  irq_o,
  input logic                  halt_o,
  input logic [PIN_SLOTS-1:0]  pin_state_o,
  input logic [KNOWN_PINS-1:0] pin_evt,
  input logic [KNOWN_PINS-1:0] pin_lvl,
  input logic [PIN_SLOTS-1:0]  ign_evt
);
  localparam logic [PIN_SLOTS-1:0]  UNK_MASK  = ~((PIN_SLOTS'(1) << KNOWN_PINS) - PIN_SLOTS'(1));
  localparam logic [KNOWN_PINS-1:0] HRST_ONLY = KNOWN_PINS'(1) << PIN_HRST;

  AST_IRQ_SUMMARY: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|pend_o)); // R9
  AST_HALT_TRACK: assert property (@(posedge clk) disable iff (rst)
    halt_o == pin_state_o[PIN_CSTOP]); // R6
  AST_EXT_LEVEL: assert property (@(posedge clk) disable iff (rst)
    pend_o[PB_EXT] == pin_state_o[PIN_EXT]); // R4
  AST_SRST_LEVEL: assert property (@(posedge clk) disable iff (rst)
    pend_o[PB_SRST] == pin_state_o[PIN_SRST]); // R7
  AST_MCK_SET: assert property (@(posedge clk) disable iff (rst)
    ($fell(pin_state_o[PIN_MCK]) && !$past(ack_i[PB_MCK])) |-> pend_o[PB_MCK]); // R5
  AST_MCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    (pend_o[PB_MCK] && !ack_i[PB_MCK]) |=> pend_o[PB_MCK]); // R5
  AST_ACK_WINS: assert property (@(posedge clk) disable iff (rst)
    ack_i[PB_MCK] |=> !pend_o[PB_MCK]); // R10
  AST_STATE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (pin_evt != '0) |=>
      ((pin_state_o[KNOWN_PINS-1:0] & $past(pin_evt)) == ($past(pin_lvl) & $past(pin_evt)))); // R2
  AST_UNKNOWN_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (ign_evt != '0) |=> ((pin_state_o & UNK_MASK) == '0)); // R3
  AST_HRST_QUIET: assert property (@(posedge clk) disable iff (rst)
    (pin_evt == HRST_ONLY && ack_i == 4'b0) |=> ($stable(pend_o) && $stable(halt_o))); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (pend_o == 4'b0 && !irq_o && !halt_o && pin_state_o == '0)); // R11
endmodule

bind cpu_pin_cond cpu_pin_cond_chk #(.PIN_SLOTS(PIN_SLOTS)) u_chk (
  .clk(clk), .rst(rst), .ack_i(ack_i), .pend_o(pend_o), .irq_o(irq_o),
  .halt_o(halt_o), .pin_state_o(pin_state_o), .pin_evt(pin_evt),
  .pin_lvl(pin_lvl), .ign_evt(ign_evt)
);

// File: tb/sim_cpu_pin_cond.sv
module sim_cpu_pin_cond;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pin = 8'h00;
  logic [3:0] ack = 4'h0;
  logic [3:0] pend;
  logic       irq, halt;
  logic [7:0] pst;

  cpu_pin_cond u0 (
    .clk(clk), .rst(rst), .pin_i(pin), .ack_i(ack),
    .pend_o(pend), .irq_o(irq), .halt_o(halt), .pin_state_o(pst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int         due;
    logic [7:0] st;
    logic [3:0] pd;
    logic       hl;
    string      req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;

  // bench model of the expected output state
  logic [7:0] m_st = 8'h00;
  logic [3:0] m_pd = 4'h0;
  logic       m_hl = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic cmp(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, got, exp, cyc);
    end
  endtask

  task automatic push(input int due, input string req);
    exp_t e;
    e.due = due; e.st = m_st; e.pd = m_pd; e.hl = m_hl; e.req = req;
    q.push_back(e);
  endtask

  // monitor: compares every item whose due edge has passed
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      if (e.due < cyc) begin
        n_chk++; n_fail++;
        $display("FAIL %s late compare: actual cycle %0d expected %0d", e.req, cyc, e.due);
      end else begin
        cmp(e.req, "pin_state", int'(pst), int'(e.st));
        cmp(e.req, "pend", int'(pend), int'(e.pd));
        cmp(e.req, "irq", int'(irq), int'(|e.pd));
        cmp(e.req, "halt", int'(halt), int'(e.hl));
      end
    end
  end

  // drive a pin vector; old outputs due at +2 (R1), new outputs at +3
  task automatic drive_pins(input logic [7:0] p, input string req);
    logic fall;
    @(negedge clk);
    pin = p;
    push(cyc + 2, "R1");
    fall = m_st[2] & ~p[2];
    m_st = p & 8'h3F;
    m_pd = {p[5], m_pd[2] | fall, p[1], p[0]};
    m_hl = p[3];
    push(cyc + 3, req);
    repeat (4) @(negedge clk);
  endtask

  // one-cycle acknowledge; level bits stay with their pins
  task automatic pulse_ack(input logic [3:0] a, input string req);
    @(negedge clk);
    ack = a;
    m_pd[2] = m_pd[2] & ~a[2];
    push(cyc + 1, req);
    @(negedge clk);
    ack = 4'h0;
    repeat (2) @(negedge clk);
  endtask

  // machine-check falls with acknowledge high at the accepting edge
  task automatic ack_race();
    int k;
    @(negedge clk);
    pin[2] = 1'b0;
    k = cyc;
    m_st[2] = 1'b0;
    m_pd[2] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    ack = 4'b0100;
    @(negedge clk);
    ack = 4'h0;
    push(k + 3, "R10");
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    push(cyc, "R11");                 // reset state
    @(negedge clk);
    // R4 ext and smi levels
    drive_pins(8'h01, "R4");
    drive_pins(8'h03, "R4");
    drive_pins(8'h02, "R4");
    drive_pins(8'h00, "R9");
    // R5 machine-check edge rules
    drive_pins(8'h04, "R5");
    drive_pins(8'h00, "R5");
    drive_pins(8'h04, "R5");
    drive_pins(8'h04, "R2");          // repeated level
    // R10 acknowledge with an ext level still high
    drive_pins(8'h05, "R10");
    pulse_ack(4'b1111, "R10");
    drive_pins(8'h04, "R10");
    ack_race();
    // R6 checkstop halt
    drive_pins(8'h08, "R6");
    drive_pins(8'h00, "R6");
    // R7 soft reset level
    drive_pins(8'h20, "R7");
    drive_pins(8'h00, "R7");
    // R8 hard reset recorded only
    drive_pins(8'h10, "R8");
    // R3 unknown slots
    drive_pins(8'hD0, "R3");
    drive_pins(8'hC0, "R3");
    // R9 summary stays up while a bit remains
    drive_pins(8'h21, "R9");
    drive_pins(8'h20, "R9");
    drive_pins(8'h00, "R9");
    // R11 reset in the middle of activity
    drive_pins(8'h2B, "R11");
    @(negedge clk);
    rst = 1'b1;
    m_st = 8'h00; m_pd = 4'h0; m_hl = 1'b0;
    push(cyc + 1, "R11");
    @(negedge clk);
    pin = 8'h00;
    @(negedge clk);
    rst = 1'b0;
    push(cyc + 3, "R11");
    repeat (6) @(negedge clk);
    finish_run();
  end
endmodule